// File: doc/BRIEF.md
# Vector Word Multiply-Accumulate Unit

This execution unit serves a 64-bit vector extension. Each accepted operation brings two 64-bit source operands, a function code and the register index of the second source field. The multiply operations take only the low 32-bit word of each source and form the full 64-bit product, as unsigned or as signed (two's complement) values. Depending on the operation, the product goes only to the destination, is also loaded into a private 64-bit accumulator, or is added to that accumulator. An accumulate returns the new sum, not the product, to the destination. A move operation copies source A unchanged to the destination and loads it into the accumulator.

An extension-enable input gates every operation. When it is low the unit reports an unavailable-unit exception and writes nothing. Function codes it does not know give an illegal-instruction indication and also write nothing. The unit accepts one operation per cycle with a fixed two-cycle latency. The destination value, its write strobe and both exception strobes come out together on one result-valid cycle. Register-file access and hazard handling belong to the surrounding pipeline.

Top module: `vwmac_unit`

## Requirements
- R1: During reset `in_ready` and `out_valid` are low, and the accumulator holds zero after reset.
- R2: The unsigned multiply has group 0x11, minor 0x0C and select 0. Here `func_code[10:6]` is the group, `func_code[5:1]` is the minor code and `func_code[0]` is the select bit. It writes zext(A[31:0])·zext(B[31:0]) as 64 bits to the destination and leaves the accumulator unchanged.
- R3: The signed multiply uses the same group and minor code with select 1. It sign-extends both low words before multiplying and leaves the accumulator unchanged.
- R4: Multiply-and-load has group 0x11 and minor 0x1C, with select 0 for unsigned and 1 for signed. It writes the product to the destination and also loads the product into the accumulator.
- R5: Multiply-and-accumulate has group 0x15 and minor 0x0C, with select 0 for unsigned and 1 for signed. It adds the product to the accumulator modulo 2^64, with no saturation, and writes the new sum to the destination.
- R6: The move has group 0x13, minor 0x02, select 0 and `rb_idx` equal to 0. It writes source A unchanged to the destination and loads all 64 bits of A into the accumulator.
- R7: With `ext_en` low, any accepted operation gives `unavail_exc`=1, `rd_we`=0 and `rd_data`=0, and leaves the accumulator unchanged.
- R8: With `ext_en` high, an unknown group/minor pair gives `illegal_exc`=1, `rd_we`=0 and `rd_data`=0, and leaves the accumulator unchanged. So does a move with select 1 or a nonzero `rb_idx`. At most one of `rd_we`, `unavail_exc` and `illegal_exc` is high.
- R9: An operation accepted at a clock edge presents its result with `out_valid` high after the second following edge. `in_ready` is high outside reset, so operations may be issued back to back. `out_valid` is never high without a matching accepted operation.
- R10: The multiply operations ignore bits 63:32 of both sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation |
| ext_en | input | 1 | Vector extension enable |
| func_code | input | 11 | {group[4:0], minor[4:0], select} |
| rb_idx | input | 5 | Second source register field, must be zero for the move |
| src_a | input | 64 | Source operand A |
| src_b | input | 64 | Source operand B |
| out_valid | output | 1 | Result cycle |
| rd_data | output | 64 | Destination value, zero when no write |
| rd_we | output | 1 | Destination write strobe |
| unavail_exc | output | 1 | Unit-unavailable exception |
| illegal_exc | output | 1 | Illegal-instruction indication |

## Verification
Some properties are checked on every cycle. Every accepted operation gives exactly one result two edges later, and the three result strobes never overlap. After a load or a move the accumulator equals the returned value, and after an accumulate it equals the returned sum. A plain multiply or a trapped operation leaves the accumulator as it was. The arithmetic values are shown only by the bench scenarios, which compare against a reference model: the unsigned and signed products at extreme operands, the ignored upper words, the wrap of the 64-bit sum, and that trapped operations leave the accumulator untouched. The bench reads the accumulator back through a zero-operand accumulate.

// File: rtl/vwmac_pkg.sv
package vwmac_pkg;

    localparam int VW_DATA_W  = 64;
    localparam int VW_GRP_W   = 5;
    localparam int VW_MINOR_W = 5;
    localparam int VW_RIDX_W  = 5;
    localparam int VW_FUNC_W  = VW_GRP_W + VW_MINOR_W + 1;
    localparam int VW_KEY_W   = VW_GRP_W + VW_MINOR_W;

    // function slots: {group, minor}; select bit chooses unsigned/signed
    localparam logic [VW_GRP_W-1:0]   GRP_MULW  = 5'h11;
    localparam logic [VW_GRP_W-1:0]   GRP_MOVE  = 5'h13;
    localparam logic [VW_GRP_W-1:0]   GRP_MACW  = 5'h15;
    localparam logic [VW_MINOR_W-1:0] MIN_MUL   = 5'h0C;
    localparam logic [VW_MINOR_W-1:0] MIN_MULLD = 5'h1C;
    localparam logic [VW_MINOR_W-1:0] MIN_MAC   = 5'h0C;
    localparam logic [VW_MINOR_W-1:0] MIN_MOVE  = 5'h02;

    typedef enum logic [2:0] {
        K_NONE,
        K_MUL,
        K_MULLD,
        K_MAC,
        K_MOVE
    } op_kind_e;

    typedef enum logic [1:0] {
        ACC_KEEP,
        ACC_LOAD,
        ACC_ADD
    } acc_mode_e;

    typedef struct packed {
        op_kind_e kind;
        logic     sgn;
        logic     unavail;
        logic     illegal;
    } dec_op_t;

    function automatic logic [VW_KEY_W-1:0] slot_key(
        input logic [VW_GRP_W-1:0]   grp,
        input logic [VW_MINOR_W-1:0] minor
    );
        return {grp, minor};
    endfunction

endpackage

// File: rtl/vwmac_decode.sv
module vwmac_decode
    import vwmac_pkg::*;
(
    input  logic                 en,
    input  logic [VW_FUNC_W-1:0] func,
    input  logic [VW_RIDX_W-1:0] rb_idx,
    output dec_op_t              op
);

    logic [VW_GRP_W-1:0]   grp;
    logic [VW_MINOR_W-1:0] minor;
    logic                  sel;

    assign grp   = func[VW_FUNC_W-1 -: VW_GRP_W];
    assign minor = func[VW_MINOR_W:1];
    assign sel   = func[0];

    always_comb begin
        op = '{kind: K_NONE, sgn: sel, unavail: 1'b0, illegal: 1'b0};
        if (!en) begin
            op.unavail = 1'b1;
        end else begin
            case (slot_key(grp, minor))
                slot_key(GRP_MULW, MIN_MUL):   op.kind = K_MUL;
                slot_key(GRP_MULW, MIN_MULLD): op.kind = K_MULLD;
                slot_key(GRP_MACW, MIN_MAC):   op.kind = K_MAC;
                slot_key(GRP_MOVE, MIN_MOVE): begin
                    if (sel || (rb_idx != '0)) op.illegal = 1'b1;
                    else                       op.kind    = K_MOVE;
                end
                default: op.illegal = 1'b1;
            endcase
        end
    end

    always_comb begin
        a_r8_decode_excl: assert (!(op.illegal && op.unavail));
    end

endmodule

// File: rtl/vwmac_mul.sv
module vwmac_mul #(
    parameter int HALF_W = 32
) (
    input  logic [HALF_W-1:0]   a,
    input  logic [HALF_W-1:0]   b,
    input  logic                sgn,
    output logic [2*HALF_W-1:0] prod
);

    localparam int FULL_W = 2 * HALF_W + 2;

    logic signed [HALF_W:0]   ax;
    logic signed [HALF_W:0]   bx;
    logic signed [FULL_W-1:0] full;
    logic                     top_unused;

    // one extra bit makes both readings fit a single signed multiplier
    assign ax   = $signed({sgn & a[HALF_W-1], a});
    assign bx   = $signed({sgn & b[HALF_W-1], b});
    assign full = ax * bx;
    assign prod = full[2*HALF_W-1:0];
    assign top_unused = ^full[FULL_W-1:2*HALF_W];

endmodule

// File: rtl/vwmac_acc.sv
module vwmac_acc
    import vwmac_pkg::*;
#(
    parameter int W = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  acc_mode_e mode,
    input  logic [W-1:0] operand,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] acc_sum
);

    assign acc_sum = acc_q + operand;   // wraps modulo 2^W

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            case (mode)
                ACC_LOAD: acc_q <= operand;
                ACC_ADD:  acc_q <= acc_sum;
                default:  acc_q <= acc_q;
            endcase
        end
    end

    a_r4_load_takes_operand: assert property (@(posedge clk) disable iff (rst)
        (mode == ACC_LOAD) |=> (acc_q == $past(operand)));

    a_r1_zero_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (acc_q == '0));

endmodule

// File: rtl/vwmac_unit.sv
module vwmac_unit
    import vwmac_pkg::*;
#(
    parameter int DATA_W = VW_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 ext_en,
    input  logic [VW_FUNC_W-1:0] func_code,
    input  logic [VW_RIDX_W-1:0] rb_idx,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_we,
    output logic                 unavail_exc,
    output logic                 illegal_exc
);

    localparam int HALF_W = DATA_W / 2;

    logic fire;
    assign in_ready = !rst;
    assign fire     = in_valid && in_ready;

    // ---------------- stage 1: decode and capture ----------------
    dec_op_t dec;

    vwmac_decode u_dec (
        .en     (ext_en),
        .func   (func_code),
        .rb_idx (rb_idx),
        .op     (dec)
    );

    logic              s1_valid;
    dec_op_t           s1_op;
    logic [DATA_W-1:0] s1_a;
    logic [HALF_W-1:0] s1_b;
    logic              b_hi_unused;

    assign b_hi_unused = ^src_b[DATA_W-1:HALF_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_op    <= '{kind: K_NONE, sgn: 1'b0, unavail: 1'b0, illegal: 1'b0};
            s1_a     <= '0;
            s1_b     <= '0;
        end else begin
            s1_valid <= fire;
            if (fire) begin
                s1_op <= dec;
                s1_a  <= src_a;
                s1_b  <= src_b[HALF_W-1:0];
            end
        end
    end

    // ---------------- stage 2: multiply, accumulate, result ----------------
    logic [DATA_W-1:0] prod;

    vwmac_mul #(.HALF_W(HALF_W)) u_mul (
        .a    (s1_a[HALF_W-1:0]),
        .b    (s1_b),
        .sgn  (s1_op.sgn),
        .prod (prod)
    );

    acc_mode_e         acc_mode;
    logic [DATA_W-1:0] acc_operand;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_sum;

    vwmac_acc #(.W(DATA_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .mode    (acc_mode),
        .operand (acc_operand),
        .acc_q   (acc_q),
        .acc_sum (acc_sum)
    );

    logic [DATA_W-1:0] res_val;
    logic              res_we;
    op_kind_e          kind_eff;

    assign kind_eff = s1_valid ? s1_op.kind : K_NONE;

    always_comb begin
        acc_mode    = ACC_KEEP;
        acc_operand = prod;
        res_val     = '0;
        res_we      = 1'b0;
        case (kind_eff)
            K_MUL: begin
                res_val = prod;
                res_we  = 1'b1;
            end
            K_MULLD: begin
                acc_mode = ACC_LOAD;
                res_val  = prod;
                res_we   = 1'b1;
            end
            K_MAC: begin
                acc_mode = ACC_ADD;
                res_val  = acc_sum;
                res_we   = 1'b1;
            end
            K_MOVE: begin
                acc_mode    = ACC_LOAD;
                acc_operand = s1_a;
                res_val     = s1_a;
                res_we      = 1'b1;
            end
            default: ;
        endcase
    end

    op_kind_e out_kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            rd_data     <= '0;
            rd_we       <= 1'b0;
            unavail_exc <= 1'b0;
            illegal_exc <= 1'b0;
            out_kind    <= K_NONE;
        end else begin
            out_valid   <= s1_valid;
            rd_data     <= res_val;
            rd_we       <= res_we;
            unavail_exc <= s1_valid && s1_op.unavail;
            illegal_exc <= s1_valid && s1_op.illegal;
            out_kind    <= kind_eff;
        end
    end

    // ---------------- assertions ----------------
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        fire |-> ##2 out_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(fire, 2));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_we, unavail_exc, illegal_exc}));

    a_r7_no_write_on_trap: assert property (@(posedge clk) disable iff (rst)
        (unavail_exc || illegal_exc) |-> (!rd_we && rd_data == '0 && out_valid));

    a_r7_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (unavail_exc || illegal_exc || out_kind == K_MUL))
            |-> (acc_q == $past(acc_q)));

    a_r4_load_visible: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_kind == K_MULLD || out_kind == K_MOVE)) |-> (acc_q == rd_data));

    a_r5_sum_visible: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == K_MAC) |-> (acc_q == rd_data && rd_we));

endmodule

// File: tb/sim_vwmac_unit.sv
`timescale 1ns/1ps
module sim_vwmac_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        ext_en = 1'b0;
    logic [10:0] func_code = '0;
    logic [4:0]  rb_idx = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] rd_data;
    logic        rd_we;
    logic        unavail_exc;
    logic        illegal_exc;

    always #10 clk = ~clk;   // 50 MHz

    vwmac_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .ext_en(ext_en), .func_code(func_code), .rb_idx(rb_idx),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .rd_data(rd_data), .rd_we(rd_we), .unavail_exc(unavail_exc),
        .illegal_exc(illegal_exc)
    );

    localparam logic [10:0] F_MUL_U   = {5'h11, 5'h0C, 1'b0};
    localparam logic [10:0] F_MUL_S   = {5'h11, 5'h0C, 1'b1};
    localparam logic [10:0] F_MULLD_U = {5'h11, 5'h1C, 1'b0};
    localparam logic [10:0] F_MULLD_S = {5'h11, 5'h1C, 1'b1};
    localparam logic [10:0] F_MAC_U   = {5'h15, 5'h0C, 1'b0};
    localparam logic [10:0] F_MAC_S   = {5'h15, 5'h0C, 1'b1};
    localparam logic [10:0] F_MOVE    = {5'h13, 5'h02, 1'b0};

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    logic [63:0] m_acc = '0;

    // two-deep expectation pipeline
    bit          d1_v = 0, d2_v = 0;
    logic [63:0] d1_data = '0, d2_data = '0;
    bit          d1_we = 0, d2_we = 0, d1_un = 0, d2_un = 0, d1_il = 0, d2_il = 0;
    string       d1_tag = "R9", d2_tag = "R9";
    string       tag_override = "";

    function automatic logic [63:0] ref_prod(input logic [63:0] a, input logic [63:0] b, input bit s);
        logic [63:0] ea, eb;
        if (s) begin
            ea = {{32{a[31]}}, a[31:0]};
            eb = {{32{b[31]}}, b[31:0]};
        end else begin
            ea = {32'h0, a[31:0]};
            eb = {32'h0, b[31:0]};
        end
        return ea * eb;
    endfunction

    task automatic check(input string tag, input bit ok, input string what);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic check_output();
        if (d2_v) begin
            check(d2_tag,
                  out_valid && rd_data == d2_data && rd_we == d2_we &&
                  unavail_exc == d2_un && illegal_exc == d2_il,
                  $sformatf("actual v=%0b data=%h we=%0b un=%0b il=%0b expected v=1 data=%h we=%0b un=%0b il=%0b",
                            out_valid, rd_data, rd_we, unavail_exc, illegal_exc,
                            d2_data, d2_we, d2_un, d2_il));
        end else begin
            check("R9", !out_valid,
                  $sformatf("actual out_valid=%0b expected 0", out_valid));
        end
    endtask

    task automatic drive(input bit v, input bit en, input logic [10:0] f,
                         input logic [4:0] rbi, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] p;
        @(negedge clk);
        check_output();
        d2_v = d1_v; d2_data = d1_data; d2_we = d1_we; d2_un = d1_un; d2_il = d1_il; d2_tag = d1_tag;
        in_valid = v; ext_en = en; func_code = f; rb_idx = rbi; src_a = a; src_b = b;
        d1_v = v; d1_data = '0; d1_we = 0; d1_un = 0; d1_il = 0; d1_tag = "R9";
        if (v) begin
            p = ref_prod(a, b, f[0]);
            if (!en) begin
                d1_un = 1; d1_tag = "R7";
            end else if (f[10:1] == F_MUL_U[10:1]) begin
                d1_data = p; d1_we = 1; d1_tag = f[0] ? "R3" : "R2";
            end else if (f[10:1] == F_MULLD_U[10:1]) begin
                d1_data = p; d1_we = 1; m_acc = p; d1_tag = "R4";
            end else if (f[10:1] == F_MAC_U[10:1]) begin
                m_acc = m_acc + p; d1_data = m_acc; d1_we = 1; d1_tag = "R5";
            end else if (f == F_MOVE && rbi == 5'd0) begin
                m_acc = a; d1_data = a; d1_we = 1; d1_tag = "R6";
            end else begin
                d1_il = 1; d1_tag = "R8";
            end
            if (tag_override != "") d1_tag = tag_override;
        end
        tag_override = "";
    endtask

    task automatic idle();
        drive(0, 1, '0, '0, '0, '0);
    endtask

    task automatic read_acc(input string tag);
        tag_override = tag;
        drive(1, 1, F_MAC_U, 5'd0, 64'hFFFF_FFFF_0000_0000, 64'hABCD_0000_0000_0000);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) begin
            @(negedge clk);
            check("R1", !in_ready && !out_valid,
                  $sformatf("actual ready=%0b valid=%0b expected 0 0", in_ready, out_valid));
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", in_ready, $sformatf("actual in_ready=%0b expected 1", in_ready));

        read_acc("R1");
        drive(1, 1, F_MUL_U, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
        drive(1, 1, F_MUL_S, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
        drive(1, 1, F_MUL_S, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
        drive(1, 1, F_MUL_S, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002);
        tag_override = "R10";
        drive(1, 1, F_MUL_U, 0, 64'hDEAD_BEEF_0000_0003, 64'h1234_5678_0000_0005);
        tag_override = "R10";
        drive(1, 1, F_MULLD_S, 0, 64'h7777_0000_FFFF_FFFD, 64'h8888_0000_0000_0007);
        read_acc("R4");
        drive(1, 1, F_MULLD_U, 0, 64'd5, 64'd7);
        read_acc("R4");
        drive(1, 1, F_MOVE, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        read_acc("R6");
        drive(1, 1, F_MAC_S, 0, 64'd1, 64'd1);          // wraps to zero
        read_acc("R5");
        drive(1, 1, F_MOVE, 5'd3, 64'h1111_2222_3333_4444, 64'h0);
        drive(1, 1, {5'h13, 5'h02, 1'b1}, 0, 64'h5555, 64'h0);
        drive(1, 1, {5'h11, 5'h0D, 1'b0}, 0, 64'h5555, 64'h6666);
        read_acc("R8");
        drive(1, 0, F_MULLD_U, 0, 64'd9, 64'd9);
        drive(1, 0, F_MOVE, 0, 64'h9999, 64'h0);
        read_acc("R7");
        drive(1, 1, F_MUL_U, 0, 64'd11, 64'd13);
        read_acc("R2");

        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a, b;
            logic [10:0] f;
            logic [4:0]  rbi;
            bit v, en;
            int k;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            k = $urandom % 8;
            if (k == 0) a[31:0] = 32'h8000_0000;
            if (k == 1) b[31:0] = 32'hFFFF_FFFF;
            rbi = 5'd0;
            case ($urandom % 9)
                0: f = F_MUL_U;
                1: f = F_MUL_S;
                2: f = F_MULLD_U;
                3: f = F_MULLD_S;
                4: f = F_MAC_U;
                5: f = F_MAC_S;
                6: f = F_MOVE;
                7: begin f = F_MOVE; rbi = 5'($urandom); end
                default: f = 11'($urandom);
            endcase
            v  = ($urandom % 5) != 0;
            en = ($urandom % 10) != 0;
            drive(v, en, f, rbi, a, b);
        end

        idle();
        idle();
        idle();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL R9: watchdog expired, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule